// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records when an external event happens, measured against a free-running counter that lives outside it. The event line is taken from either a dedicated capture pin or the output of an analog comparator. It is resynchronized to the local clock and can optionally be passed through a glitch filter. An edge detector then picks out the chosen transition. On a qualified transition the block copies the present counter value into a capture register and raises a sticky flag. The flag can be routed to an interrupt line through an enable.

Software-facing registers are not part of this block. The selects, enables and flag clear are plain inputs that a surrounding register file drives. The capture register is always readable at its output.

Top module: `capture_unit`

## Requirements
- R1: After reset, `cap_val_o` is 0, `cap_flag_o` is 0 and `irq_o` is 0.
- R2: With `src_sel_i` = 0 the trigger is `pin_i`. With the filter off, a qualifying change of `pin_i` applied before clock edge E0 loads `cap_val_o` at edge E2 with the `count_i` value present just before E2, and `cap_flag_o` rises at that edge and not earlier.
- R3: With `src_sel_i` = 1 the trigger is `cmp_i`, and activity on `pin_i` causes no capture.
- R4: `edge_rise_i` = 1 selects low-to-high transitions and `edge_rise_i` = 0 selects high-to-low transitions. The opposite transition causes no capture.
- R5: With `filt_en_i` = 1, a new level is accepted only after it has been seen on four consecutive synchronized samples. A held change therefore captures four clock edges later than without the filter (at E6, with the count from just before E6). A pulse lasting three clocks or less causes no capture.
- R6: With `filt_en_i` = 0, a one-clock pulse on the selected source is enough to capture.
- R7: `cap_flag_o` stays set until `flag_clr_i` is high at a clock edge. A capture at the same edge as a clear leaves the flag set.
- R8: `irq_o` is high exactly when `cap_flag_o` is set and `irq_en_i` is 1.
- R9: A second capture before the flag is cleared overwrites `cap_val_o` with the newer count.
- R10: `cap_val_o` keeps its value at every edge where no capture occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | CW | Running counter value to be timestamped |
| pin_i | input | 1 | External capture pin (asynchronous) |
| cmp_i | input | 1 | Analog comparator output (asynchronous) |
| src_sel_i | input | 1 | Trigger source: 0 pin, 1 comparator |
| filt_en_i | input | 1 | 1 enables the glitch filter |
| edge_rise_i | input | 1 | 1 rising, 0 falling transition captures |
| flag_clr_i | input | 1 | Clears the capture flag |
| irq_en_i | input | 1 | Interrupt enable for the flag |
| cap_val_o | output | CW | Captured counter value |
| cap_flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit count, two synchronizer stages and a four-sample filter. At these values the full three-edge and seven-edge latencies are short enough to check for exact cycles. A bench counter that wraps at 16 bits feeds `count_i`, so every expected timestamp follows directly from the cycle on which the stimulus was applied. The four-sample window allows a three-clock pulse to sit one sample short of acceptance, which tests the filter boundary directly.

// File: rtl/capture_unit.sv
module capture_unit #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          pin_i,
  input  logic          cmp_i,
  input  logic          src_sel_i,
  input  logic          filt_en_i,
  input  logic          edge_rise_i,
  input  logic          flag_clr_i,
  input  logic          irq_en_i,
  output logic [CW-1:0] cap_val_o,
  output logic          cap_flag_o,
  output logic          irq_o
);
  // history excludes the newest sample, which is compared live
  localparam int HW = FILT_LEN - 1;

  logic                   src;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic [HW-1:0]          hist_q;
  logic                   agree;
  logic                   filt_q;
  logic                   det;
  logic                   prev_q;
  logic                   cap_evt;

  assign src = src_sel_i ? cmp_i : pin_i;
  assign smp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], src};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[HW-2:0], smp};
  end

  assign agree = (hist_q == {HW{smp}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     filt_q <= 1'b0;
    else if (agree) filt_q <= smp;
  end

  assign det = filt_en_i ? filt_q : smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= det;
  end

  assign cap_evt = edge_rise_i ? (det & ~prev_q) : (~det & prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_val_o <= '0;
    else if (cap_evt) cap_val_o <= count_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cap_flag_o <= 1'b0;
    else if (cap_evt)    cap_flag_o <= 1'b1;
    else if (flag_clr_i) cap_flag_o <= 1'b0;
  end

  assign irq_o = cap_flag_o & irq_en_i;
endmodule

// File: rtl/capture_unit_chk.sv
module capture_unit_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count_i,
  input logic          flag_clr_i,
  input logic          irq_en_i,
  input logic          cap_evt,
  input logic [CW-1:0] cap_val_o,
  input logic          cap_flag_o,
  input logic          irq_o
);
  a_r2_load_count: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_val_o == $past(count_i));

  a_r10_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val_o));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag_o);

  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !cap_evt) |=> !cap_flag_o);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag_o && !flag_clr_i) |=> cap_flag_o);

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cap_flag_o && irq_en_i));
endmodule

bind capture_unit capture_unit_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_i(count_i), .flag_clr_i(flag_clr_i),
  .irq_en_i(irq_en_i), .cap_evt(cap_evt), .cap_val_o(cap_val_o),
  .cap_flag_o(cap_flag_o), .irq_o(irq_o)
);

// File: tb/tb_capture_unit.sv
`timescale 1ns/1ps
module tb_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        pin = 1'b0, cmp = 1'b0, src_sel = 1'b0, filt_en = 1'b0;
  logic        edge_rise = 1'b1, flag_clr = 1'b0, irq_en = 1'b0;
  logic [15:0] cap_val;
  logic        cap_flag, irq;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] c0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) cnt <= cnt + 16'd1;

  capture_unit dut (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .pin_i(pin), .cmp_i(cmp),
    .src_sel_i(src_sel), .filt_en_i(filt_en), .edge_rise_i(edge_rise),
    .flag_clr_i(flag_clr), .irq_en_i(irq_en), .cap_val_o(cap_val),
    .cap_flag_o(cap_flag), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cap_val", cap_val, 0);
    chk("R1 flag", cap_flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_pin_rise();
    @(negedge clk) begin pin = 1'b1; c0 = cnt; end
    cyc(2);
    chk("R2 no early flag", cap_flag, 0);
    cyc(1);
    chk("R2 flag", cap_flag, 1);
    chk("R2 cap_val", cap_val, c0 + 16'd2);
    pin = 1'b0;
    cyc(6);
    chk("R4 falling ignored flag", cap_flag, 1);
    chk("R10 value held", cap_val, c0 + 16'd2);
  endtask

  task automatic t_flag_irq();
    irq_en = 1'b0; #1;
    chk("R8 masked", irq, 0);
    irq_en = 1'b1; #1;
    chk("R8 enabled", irq, 1);
    cyc(3);
    chk("R7 sticky", cap_flag, 1);
    clear_flag();
    chk("R7 cleared", cap_flag, 0);
    chk("R8 no flag", irq, 0);
  endtask

  task automatic t_comparator();
    @(negedge clk) src_sel = 1'b1;
    @(negedge clk) pin = 1'b1;
    cyc(6);
    pin = 1'b0;
    cyc(6);
    chk("R3 pin ignored", cap_flag, 0);
    @(negedge clk) begin cmp = 1'b1; c0 = cnt; end
    cyc(3);
    chk("R3 cmp flag", cap_flag, 1);
    chk("R3 cmp cap_val", cap_val, c0 + 16'd2);
    cmp = 1'b0;
    cyc(6);
    src_sel = 1'b0;
    clear_flag();
  endtask

  task automatic t_falling();
    @(negedge clk) edge_rise = 1'b0;
    @(negedge clk) pin = 1'b1;
    cyc(6);
    chk("R4 rising ignored", cap_flag, 0);
    @(negedge clk) begin pin = 1'b0; c0 = cnt; end
    cyc(3);
    chk("R4 falling flag", cap_flag, 1);
    chk("R4 falling cap_val", cap_val, c0 + 16'd2);
    cyc(4);
    edge_rise = 1'b1;
    clear_flag();
  endtask

  task automatic t_filter();
    @(negedge clk) filt_en = 1'b1;
    cyc(6);
    @(negedge clk) pin = 1'b1;
    cyc(3);
    pin = 1'b0;
    cyc(12);
    chk("R5 short pulse rejected", cap_flag, 0);
    @(negedge clk) begin pin = 1'b1; c0 = cnt; end
    cyc(6);
    chk("R5 no early flag", cap_flag, 0);
    cyc(1);
    chk("R5 filtered flag", cap_flag, 1);
    chk("R5 filtered cap_val", cap_val, c0 + 16'd6);
    pin = 1'b0;
    cyc(12);
    filt_en = 1'b0;
    cyc(2);
    clear_flag();
  endtask

  task automatic t_short_unfiltered();
    @(negedge clk) begin pin = 1'b1; c0 = cnt; end
    @(negedge clk) pin = 1'b0;
    cyc(2);
    chk("R6 one-clock pulse flag", cap_flag, 1);
    chk("R6 one-clock pulse cap_val", cap_val, c0 + 16'd2);
    cyc(4);
    clear_flag();
  endtask

  task automatic t_overwrite_and_priority();
    @(negedge clk) pin = 1'b1;
    @(negedge clk) pin = 1'b0;
    cyc(6);
    chk("R9 first capture", cap_flag, 1);
    @(negedge clk) begin pin = 1'b1; c0 = cnt; end
    cyc(2);
    flag_clr = 1'b1;
    cyc(1);
    flag_clr = 1'b0;
    chk("R7 set beats clear", cap_flag, 1);
    chk("R9 overwritten", cap_val, c0 + 16'd2);
    pin = 1'b0;
    cyc(6);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    #1;
    t_reset();
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_pin_rise();
    t_flag_irq();
    t_comparator();
    t_falling();
    t_filter();
    t_short_unfiltered();
    t_overwrite_and_priority();
    finish_run();
  end
endmodule